// File: doc/BRIEF.md
# Infrared Carrier Burst Transmitter

This block drives an infrared LED line from a list of timed marks and spaces that software supplies one word at a time. Each word says whether the interval is a mark or a space and how many carrier periods it lasts. During a mark the line carries a square-wave carrier whose period is set by a clock divisor. A divisor of 1500 on a 54 MHz clock gives a 36 kHz carrier, and that value is the default. During a space, or when nothing is queued, the line stays low.

Words go into a two-slot store. The word in the head slot is the one being played, and the second slot holds the word that follows, so software can load the next interval while the current one is still playing. Consecutive words play back to back with no gap. An active-high `not_full` output tells software that a slot is free. A write to a full store is discarded and raises a sticky `overflow` flag. Deasserting `enable` empties the store, clears the flag and holds the line low.

Top module: `ir_tx_top`

## Requirements
- R1: A word on `wr_data` has the mark flag in bit 15 (1 = mark, 0 = space) and the duration in bits 14:0, counted in whole carrier periods. A duration of 0 plays as one period.
- R2: The carrier period is `div_val` clock cycles. A `div_val` of 0 selects the default of 1500 cycles, and a `div_val` of 1 is treated as 2.
- R3: During a mark, `ir_out` is high for the first floor(N/2) clocks of each N-clock carrier period and low for the rest. The carrier phase restarts at the first clock of every mark.
- R4: During a space, `ir_out` is low for the whole duration.
- R5: When the store is empty, a word written at clock edge E starts playing at edge E+1. Queued words then play in write order with no gap, each one starting on the edge that ends its predecessor.
- R6: `not_full` is 1 whenever fewer than two words are held. The word being played counts as held until its last period ends.
- R7: A write while two words are held is discarded and sets `overflow` from the next clock on. `overflow` stays set until reset or until `enable` is low.
- R8: `ir_out` is low whenever the store is empty.
- R9: While `enable` is low, `ir_out` is low in that same cycle, both slots are emptied, and writes are ignored. When `enable` returns high, nothing is left to play.
- R10: After reset, `ir_out` = 0, `not_full` = 1 and `overflow` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock (54 MHz in the target system) |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Transmitter enable; low empties the store and forces the line low |
| div_val | input | 16 | Carrier period in clocks (0 = default 1500) |
| wr_en | input | 1 | Write strobe for one interval word |
| wr_data | input | 16 | Interval word: bit 15 mark flag, bits 14:0 period count |
| ir_out | output | 1 | Modulated infrared line |
| not_full | output | 1 | High while a slot is free |
| overflow | output | 1 | Sticky flag: a write was discarded |

## Verification
If the playing-word state goes wrong, it shows at once on `ir_out`. A stuck slot appears as carrier pulses after the store should be empty. A wrong remaining-period count shifts where the next mark's first high clock lands by a whole multiple of the carrier period. A fault in the divisor or the phase restart changes the number of high clocks per mark and the distance from the first rising edge to the last falling edge, and both show within a single mark. A wrong slot count shows on `not_full` or `overflow` one clock after the write that should have filled the store.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int unsigned DEFAULT_DIV = 1500;
  localparam int unsigned MIN_DIV     = 2;

  // Effective carrier period in clocks from the raw divisor field.
  function automatic int unsigned eff_period(input int unsigned raw);
    if (raw == 0)            return DEFAULT_DIV;
    else if (raw < MIN_DIV)  return MIN_DIV;
    else                     return raw;
  endfunction

  // Number of high clocks at the start of each carrier period.
  function automatic int unsigned high_clocks(input int unsigned period);
    return period / 2;
  endfunction

  // Number of carrier periods a duration field plays for.
  function automatic int unsigned play_periods(input int unsigned dur);
    return (dur == 0) ? 1 : dur;
  endfunction

endpackage

// File: rtl/ir_tx_dbuf.sv
module ir_tx_dbuf #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic [W-1:0] second,
  output logic [1:0]   fill,
  output logic         dropped
);
  logic [W-1:0] slot0_q, slot1_q;
  logic [1:0]   fill_q;
  logic         accept;

  assign accept  = wr_en && (fill_q != 2'd2);
  assign dropped = wr_en && (fill_q == 2'd2);
  assign head    = slot0_q;
  assign second  = slot1_q;
  assign fill    = fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      fill_q  <= 2'd0;
      slot0_q <= '0;
      slot1_q <= '0;
    end else begin
      unique case ({accept, pop})
        2'b01: begin
          slot0_q <= slot1_q;
          fill_q  <= fill_q - 2'd1;
        end
        2'b10: begin
          if (fill_q == 2'd0) slot0_q <= wr_data;
          else                slot1_q <= wr_data;
          fill_q <= fill_q + 2'd1;
        end
        2'b11: begin
          // pop of the only word with a fresh write: new word becomes head
          slot0_q <= wr_data;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic [DIV_W-1:0] period,
  output logic             hi,
  output logic             period_end
);
  logic [DIV_W-1:0] phase_q;
  logic [DIV_W-1:0] last_phase;
  logic [DIV_W-1:0] half;

  assign last_phase = period - DIV_W'(1);
  assign half       = DIV_W'(ir_tx_pkg::high_clocks(32'(period)));
  assign period_end = run && (phase_q >= last_phase);
  assign hi         = phase_q < half;

  always_ff @(posedge clk) begin
    if (!rst_n || !run || restart) phase_q <= '0;
    else if (phase_q >= last_phase) phase_q <= '0;
    else phase_q <= phase_q + DIV_W'(1);
  end
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [1:0]   fill,
  input  logic [W-1:0] head,
  input  logic [W-1:0] second,
  input  logic         period_end,
  output logic         pop,
  output logic         restart,
  output logic         active,
  output logic         mark
);
  localparam int DUR_W = W - 1;

  logic [DUR_W-1:0] remain_q;
  logic             active_q, mark_q;
  logic             start_idle, finish, chain;

  function automatic logic [DUR_W-1:0] load_of(input logic [W-1:0] word);
    return DUR_W'(ir_tx_pkg::play_periods(32'(word[DUR_W-1:0])));
  endfunction

  assign start_idle = !active_q && (fill != 2'd0);
  assign finish     = active_q && period_end && (remain_q == DUR_W'(1));
  assign chain      = finish && (fill == 2'd2);
  assign pop        = finish;
  assign restart    = start_idle || chain;
  assign active     = active_q;
  assign mark       = mark_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      active_q <= 1'b0;
      mark_q   <= 1'b0;
      remain_q <= '0;
    end else if (start_idle) begin
      active_q <= 1'b1;
      mark_q   <= head[W-1];
      remain_q <= load_of(head);
    end else if (active_q && period_end) begin
      if (remain_q == DUR_W'(1)) begin
        if (chain) begin
          mark_q   <= second[W-1];
          remain_q <= load_of(second);
        end else begin
          active_q <= 1'b0;
          mark_q   <= 1'b0;
        end
      end else begin
        remain_q <= remain_q - DUR_W'(1);
      end
    end
  end
endmodule

// File: rtl/ir_tx_top.sv
module ir_tx_top #(
  parameter int DIV_W = 16,
  parameter int DUR_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [DIV_W-1:0]   div_val,
  input  logic               wr_en,
  input  logic [DUR_W:0]     wr_data,
  output logic               ir_out,
  output logic               not_full,
  output logic               overflow
);
  localparam int WORD_W = DUR_W + 1;

  logic              clr;
  logic [DIV_W-1:0]  period;
  logic [WORD_W-1:0] head_w, second_w;
  logic [1:0]        buf_cnt;
  logic              dropped, pop, restart;
  logic              tx_active, tx_mark;
  logic              carrier_hi, period_end;
  logic              overflow_q;

  assign clr    = !enable;
  assign period = DIV_W'(ir_tx_pkg::eff_period(32'(div_val)));

  ir_tx_dbuf #(.W(WORD_W)) dbuf_i (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .wr_en(wr_en && enable), .wr_data(wr_data), .pop(pop),
    .head(head_w), .second(second_w), .fill(buf_cnt), .dropped(dropped)
  );

  ir_tx_seq #(.W(WORD_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .fill(buf_cnt),
    .head(head_w), .second(second_w), .period_end(period_end),
    .pop(pop), .restart(restart), .active(tx_active), .mark(tx_mark)
  );

  ir_tx_carrier #(.DIV_W(DIV_W)) car_i (
    .clk(clk), .rst_n(rst_n), .run(tx_active), .restart(restart),
    .period(period), .hi(carrier_hi), .period_end(period_end)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr) overflow_q <= 1'b0;
    else if (dropped)  overflow_q <= 1'b1;
  end

  assign ir_out   = enable && tx_active && tx_mark && carrier_hi;
  assign not_full = buf_cnt != 2'd2;
  assign overflow = overflow_q;
endmodule

// File: rtl/ir_tx_chk.sv
module ir_tx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       wr_en,
  input logic       not_full,
  input logic       overflow,
  input logic       ir_out,
  input logic [1:0] buf_cnt,
  input logic       tx_active,
  input logic       tx_mark
);
  // R9
  disabled_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !ir_out);

  // R9
  disabled_store_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> buf_cnt == 2'd0);

  // R7
  drop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wr_en && !not_full) |=> overflow);

  // R7
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && enable && $past(enable)) |=> (overflow || !enable));

  // R8
  empty_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt == 2'd0 |-> !ir_out);

  // R4
  space_line_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && !tx_mark) |-> !ir_out);

  // R6
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_cnt <= 2'd2);
endmodule

bind ir_tx_top ir_tx_chk chk_i (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
  .not_full(not_full), .overflow(overflow), .ir_out(ir_out),
  .buf_cnt(buf_cnt), .tx_active(tx_active), .tx_mark(tx_mark)
);

// File: tb/ir_tx_top_tb_top.sv
module ir_tx_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] div_val = 16'd0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = 16'd0;
  logic        ir_out, not_full, overflow;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ir_tx_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .div_val(div_val),
    .wr_en(wr_en), .wr_data(wr_data), .ir_out(ir_out),
    .not_full(not_full), .overflow(overflow)
  );

  // columns: space periods, mark periods, raw divisor
  localparam int VEC [6][3] = '{
    '{2, 3, 10}, '{0, 1, 2}, '{1, 2, 1}, '{3, 4, 7}, '{1, 0, 5}, '{1, 1, 0}
  };

  function automatic int period_of(input int raw);
    int p;
    p = raw;
    if (p == 0) p = 1500;
    if (p == 1) p = 2;
    return p;
  endfunction

  function automatic int at_least_one(input int n);
    return (n < 1) ? 1 : n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  task automatic run_vec(input int sp, input int mk, input int raw);
    int n, first, last, highs, lim;
    n = period_of(raw);
    first = -1; last = -1; highs = 0;
    lim = 2 + at_least_one(sp) * n + at_least_one(mk) * n + 10;
    @(negedge clk);
    div_val = 16'(raw);
    wr_en = 1'b1;
    wr_data = {1'b0, 15'(sp)};
    @(negedge clk);
    wr_data = {1'b1, 15'(mk)};
    @(negedge clk);
    wr_en = 1'b0;
    for (int k = 2; k < lim; k++) begin
      if (ir_out) begin
        if (first < 0) first = k;
        last = k;
        highs++;
      end
      @(negedge clk);
    end
    // R5 + R1 + R4: mark starts after the whole space, 0 counts as one period
    check(first == 2 + at_least_one(sp) * n, "R5", first, 2 + at_least_one(sp) * n);
    // R3 + R2: high clocks per mark
    check(highs == at_least_one(mk) * (n / 2), "R3", highs, at_least_one(mk) * (n / 2));
    // R3: first rise to last high clock
    check(last - first == (at_least_one(mk) - 1) * n + n / 2 - 1, "R2",
          last - first, (at_least_one(mk) - 1) * n + n / 2 - 1);
    // R8: store drained, line low, slot free
    check(!ir_out && not_full, "R8", int'(ir_out), 0);
  endtask

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(ir_out == 1'b0, "R10", int'(ir_out), 0);
    check(not_full == 1'b1, "R10", int'(not_full), 1);
    check(overflow == 1'b0, "R10", int'(overflow), 0);
    rst_n = 1'b1;
    enable = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) run_vec(VEC[v][0], VEC[v][1], VEC[v][2]);

    // R6 / R7: fill the store, third write is dropped
    highs = 0;
    @(negedge clk);
    div_val = 16'd4;
    wr_en = 1'b1; wr_data = {1'b1, 15'd5};
    @(negedge clk);
    check(not_full == 1'b1, "R6", int'(not_full), 1);
    wr_data = {1'b1, 15'd5};
    @(negedge clk);
    check(not_full == 1'b0, "R6", int'(not_full), 0);
    wr_data = {1'b1, 15'd5};
    if (ir_out) highs++;
    @(negedge clk);
    wr_en = 1'b0;
    check(overflow == 1'b1, "R7", int'(overflow), 1);
    for (int k = 0; k < 60; k++) begin
      if (ir_out) highs++;
      @(negedge clk);
    end
    check(highs == 20, "R7", highs, 20);
    check(overflow == 1'b1, "R7", int'(overflow), 1);
    check(not_full == 1'b1, "R6", int'(not_full), 1);

    // R9: disable in the middle of a long mark
    wr_en = 1'b1; wr_data = {1'b1, 15'd100};
    @(negedge clk);
    wr_en = 1'b0;
    repeat (9) @(negedge clk);
    enable = 1'b0;
    #1;
    check(ir_out == 1'b0, "R9", int'(ir_out), 0);
    highs = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 5) begin wr_en = 1'b1; wr_data = {1'b1, 15'd3}; end
      if (k == 6) wr_en = 1'b0;
      if (ir_out) highs++;
    end
    check(highs == 0, "R9", highs, 0);
    check(overflow == 1'b0, "R7", int'(overflow), 0);
    enable = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (ir_out) highs++;
    end
    check(highs == 0, "R9", highs, 0);
    check(not_full == 1'b1, "R9", int'(not_full), 1);
    finish_run();
  end
endmodule